// File: doc/BRIEF.md
# Vectored Nested Priority Interrupt Controller

This block merges many interrupt sources into two requests toward a processor: a normal request and a fast request. Source 0 is the fast input. Sources 1 and up each take a 3-bit priority, a trigger type and a 32-bit vector. The processor takes a normal interrupt by reading the vector register. That read returns the handler vector of the winning source, acknowledges it and raises the current priority level. A write to the end-of-service register lowers the level again. A source of strictly higher priority can interrupt a handler that is already running, up to eight levels deep.

For debugging there are two extra controls. Protect mode makes the vector read free of side effects. A per-source force mask moves chosen normal sources onto the fast request. Configuration goes through a single-cycle synchronous register bus. Read data is registered and is valid in the cycle after the read strobe.

Top module: `intc_vnp_top`

Word address map at the default parameters:
- 0..31: source configuration, with priority in bits 2:0 and trigger type in bit 4.
- 32..63: source vectors.
- 64: enable mask.
- 65: fast-force mask.
- 66: vector/acknowledge.
- 67: end of service.
- 68: spurious vector.
- 69: protect (bit 0).
- 70: pending status.

## Requirements
- R1: After reset both requests are low. The enable mask (address 64) and the pending status (address 70) read 0. A vector read (address 66) returns the spurious register's reset value, 0.
- R2: With config bit 4 = 0 a source is level-high and is pending only while its input is 1. With bit 4 = 1 a rising edge latches a pending bit, which stays set after the input falls until the source is acknowledged. Pending status bit k at address 70 shows source k.
- R3: A source whose enable-mask bit is 0 never raises the normal request, and a vector read does not select it. Setting the bit lets the source raise the request.
- R4: Among enabled, pending, non-forced sources 1..N-1, the one with the largest priority value wins (7 is highest). On equal priority, the lowest source number wins.
- R5: A vector read while the normal request is high returns the winner's vector register (address 32+k). It acknowledges the winner: the current level is pushed, the winner's priority becomes the current level, and an edge pending bit is cleared.
- R6: While a handler is active, the normal request is raised only by a winner whose priority is strictly greater than the current level. Each write to address 67 pops one level and restores the previous one.
- R7: A vector read made while the normal request is low returns the spurious vector register (address 68) and changes no state.
- R8: With protect bit 0 of address 69 set, a vector read still returns the winner's vector. It acknowledges nothing, keeps the pending bit and leaves the level unchanged.
- R9: A source with its bit set in the fast-force mask (address 65) drives the fast request and never the normal one. Source 0 drives the fast request directly while its enable bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_in | input | 32 | Interrupt source inputs, bit 0 is the fast input |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe, ignored while bus_wr is high |
| bus_addr | input | 7 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data, valid the cycle after bus_rd |
| irq_norm | output | 1 | Normal interrupt request |
| irq_fast | output | 1 | Fast interrupt request |

## Verification
The hardest state to reach is a nested one: a handler is active and a lower-priority source is waiting, so the request must stay low and a vector read must fall back to the spurious value. The stimulus gets there by acknowledging a low-priority edge source first and then a higher one. It then pulses a third source whose priority lies between the two and checks the request and the readback. After one end-of-service write, the waiting source must win as the level returns to the first handler's level. Equal-priority ties and protect-mode double reads use pulses that land in the same cycle.

// File: rtl/intc_pkg.sv
// Package: shared constants for the vectored nested interrupt controller.
// Assumes word addressing and a control block placed right after the vectors.
package intc_pkg;
    localparam int CFG_EDGE_BIT = 4;   // trigger type bit in a config word
    localparam int CTL_EN       = 0;   // control block offsets
    localparam int CTL_FORCE    = 1;
    localparam int CTL_IVR      = 2;
    localparam int CTL_EOI      = 3;
    localparam int CTL_SPUR     = 4;
    localparam int CTL_PROT     = 5;
    localparam int CTL_PEND     = 6;
    localparam int CTL_COUNT    = 8;
endpackage

// File: rtl/intc_src_detect.sv
// Module: per-source pending detection.
// Level sources follow their input; edge sources latch a rising edge until cleared.
// Assumes inputs are already synchronous to clk.
module intc_src_detect #(
    parameter int NSRC = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] src_in,
    input  logic [NSRC-1:0] edge_sel,
    input  logic [NSRC-1:0] clr,
    output logic [NSRC-1:0] pend
);
    for (genvar g = 0; g < NSRC; g++) begin : g_src
        logic prev;
        logic held;

        // Track previous input and hold a latched rising edge.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                prev <= 1'b0;
                held <= 1'b0;
            end else begin
                prev <= src_in[g];
                if (edge_sel[g] && src_in[g] && !prev)
                    held <= 1'b1;
                else if (clr[g])
                    held <= 1'b0;
            end
        end

        assign pend[g] = edge_sel[g] ? held : src_in[g];
    end
endmodule

// File: rtl/intc_prio_arb.sv
// Module: priority arbiter over sources 1..NSRC-1.
// Largest priority wins, and on a tie the lowest index wins. Source 0 is never a candidate.
module intc_prio_arb #(
    parameter int NSRC = 32,
    parameter int PW   = 3,
    localparam int IDW = $clog2(NSRC)
) (
    input  logic [NSRC-1:0]         cand,
    input  logic [NSRC-1:0][PW-1:0] prio,
    output logic                    win_valid,
    output logic [IDW-1:0]          win_id,
    output logic [PW-1:0]           win_prio
);
    // Scan upward; only a strictly greater priority replaces the holder.
    always_comb begin
        win_valid = 1'b0;
        win_id    = '0;
        win_prio  = '0;
        for (int k = 1; k < NSRC; k++) begin
            if (cand[k] && (!win_valid || prio[k] > win_prio)) begin
                win_valid = 1'b1;
                win_id    = IDW'(k);
                win_prio  = prio[k];
            end
        end
    end
endmodule

// File: rtl/intc_level_stack.sv
// Module: current-level register with a push/pop stack of prior levels.
// Assumes push and pop are never requested in the same cycle.
module intc_level_stack #(
    parameter int PW    = 3,
    localparam int DEPTH = 2 ** PW,
    localparam int SIW   = $clog2(DEPTH),
    localparam int DW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic          pop,
    input  logic [PW-1:0] new_lvl,
    output logic [PW-1:0] cur_lvl,
    output logic [DW-1:0] depth
);
    logic [PW-1:0] stk [DEPTH];
    logic [DW-1:0] depth_m1;

    assign depth_m1 = depth - DW'(1);

    // Save the level on acknowledge, restore it on end of service.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_lvl <= '0;
            depth   <= '0;
            for (int i = 0; i < DEPTH; i++) stk[i] <= '0;
        end else if (push && depth < DW'(DEPTH)) begin
            stk[depth[SIW-1:0]] <= cur_lvl;
            cur_lvl             <= new_lvl;
            depth               <= depth + DW'(1);
        end else if (pop && depth != '0) begin
            cur_lvl <= stk[depth_m1[SIW-1:0]];
            depth   <= depth_m1;
        end
    end
endmodule

// File: rtl/intc_vnp_top.sv
// Module: vectored nested priority interrupt controller top.
// It holds the register file, qualifies sources, and drives the normal and fast requests.
// Assumes NUM_SRC <= VEC_W and PRIO_BITS <= 4.
module intc_vnp_top #(
    parameter int NUM_SRC   = 32,
    parameter int PRIO_BITS = 3,
    parameter int VEC_W     = 32,
    localparam int IDW      = $clog2(NUM_SRC),
    localparam int ADDR_W   = $clog2(2 * NUM_SRC + intc_pkg::CTL_COUNT),
    localparam int DEPTH_W  = $clog2(2 ** PRIO_BITS + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_in,
    input  logic               bus_wr,
    input  logic               bus_rd,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [VEC_W-1:0]   bus_wdata,
    output logic [VEC_W-1:0]   bus_rdata,
    output logic               irq_norm,
    output logic               irq_fast
);
    import intc_pkg::*;

    localparam logic [ADDR_W-1:0] A_EN    = ADDR_W'(2 * NUM_SRC + CTL_EN);
    localparam logic [ADDR_W-1:0] A_FORCE = ADDR_W'(2 * NUM_SRC + CTL_FORCE);
    localparam logic [ADDR_W-1:0] A_IVR   = ADDR_W'(2 * NUM_SRC + CTL_IVR);
    localparam logic [ADDR_W-1:0] A_EOI   = ADDR_W'(2 * NUM_SRC + CTL_EOI);
    localparam logic [ADDR_W-1:0] A_SPUR  = ADDR_W'(2 * NUM_SRC + CTL_SPUR);
    localparam logic [ADDR_W-1:0] A_PROT  = ADDR_W'(2 * NUM_SRC + CTL_PROT);
    localparam logic [ADDR_W-1:0] A_PEND  = ADDR_W'(2 * NUM_SRC + CTL_PEND);

    logic [NUM_SRC-1:0][PRIO_BITS-1:0] cfg_prio;
    logic [NUM_SRC-1:0]                cfg_edge;
    logic [VEC_W-1:0]                  vec_tab [NUM_SRC];
    logic [NUM_SRC-1:0]                en_mask;
    logic [NUM_SRC-1:0]                force_mask;
    logic [VEC_W-1:0]                  spur_vec;
    logic                              protect;

    logic [NUM_SRC-1:0]   pend;
    logic [NUM_SRC-1:0]   cand;
    logic [NUM_SRC-1:0]   clr_vec;
    logic                 win_valid;
    logic [IDW-1:0]       win_id;
    logic [PRIO_BITS-1:0] win_prio;
    logic [PRIO_BITS-1:0] cur_lvl;
    logic [DEPTH_W-1:0]   depth;
    logic                 rd_en;
    logic                 vec_rd;
    logic                 ack_fire;
    logic                 eoi_wr;
    logic [VEC_W-1:0]     rd_mux;

    // Bus strobes; a write wins over a simultaneous read.
    assign rd_en    = bus_rd && !bus_wr;
    assign vec_rd   = rd_en && (bus_addr == A_IVR);
    assign eoi_wr   = bus_wr && (bus_addr == A_EOI);
    assign ack_fire = vec_rd && irq_norm && !protect;

    // Register file writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_prio   <= '0;
            cfg_edge   <= '0;
            en_mask    <= '0;
            force_mask <= '0;
            spur_vec   <= '0;
            protect    <= 1'b0;
            for (int k = 0; k < NUM_SRC; k++) vec_tab[k] <= '0;
        end else if (bus_wr) begin
            for (int k = 0; k < NUM_SRC; k++) begin
                if (bus_addr == ADDR_W'(k)) begin
                    cfg_prio[k] <= bus_wdata[PRIO_BITS-1:0];
                    cfg_edge[k] <= bus_wdata[CFG_EDGE_BIT];
                end
                if (bus_addr == ADDR_W'(NUM_SRC + k))
                    vec_tab[k] <= bus_wdata;
            end
            if (bus_addr == A_EN)    en_mask    <= bus_wdata[NUM_SRC-1:0];
            if (bus_addr == A_FORCE) force_mask <= bus_wdata[NUM_SRC-1:0];
            if (bus_addr == A_SPUR)  spur_vec   <= bus_wdata;
            if (bus_addr == A_PROT)  protect    <= bus_wdata[0];
        end
    end

    // Pending detection for every source.
    intc_src_detect #(.NSRC(NUM_SRC)) u_detect (
        .clk      (clk),
        .rst_n    (rst_n),
        .src_in   (src_in),
        .edge_sel (cfg_edge),
        .clr      (clr_vec),
        .pend     (pend)
    );

    // Normal candidates exclude source 0, masked and forced sources.
    assign cand = pend & en_mask & ~force_mask & ~NUM_SRC'(1);

    intc_prio_arb #(.NSRC(NUM_SRC), .PW(PRIO_BITS)) u_arb (
        .cand      (cand),
        .prio      (cfg_prio),
        .win_valid (win_valid),
        .win_id    (win_id),
        .win_prio  (win_prio)
    );

    intc_level_stack #(.PW(PRIO_BITS)) u_stack (
        .clk     (clk),
        .rst_n   (rst_n),
        .push    (ack_fire),
        .pop     (eoi_wr),
        .new_lvl (win_prio),
        .cur_lvl (cur_lvl),
        .depth   (depth)
    );

    // Acknowledge clears the winner's latched edge.
    always_comb begin
        clr_vec = '0;
        if (ack_fire) clr_vec[win_id] = 1'b1;
    end

    // Request outputs: normal needs to beat the active level.
    assign irq_norm = win_valid && (depth == '0 || win_prio > cur_lvl);
    assign irq_fast = (src_in[0] && en_mask[0])
                    || (|(pend & en_mask & force_mask & ~NUM_SRC'(1)));

    // Read data selection.
    always_comb begin
        rd_mux = '0;
        for (int k = 0; k < NUM_SRC; k++) begin
            if (bus_addr == ADDR_W'(k)) begin
                rd_mux[PRIO_BITS-1:0]  = cfg_prio[k];
                rd_mux[CFG_EDGE_BIT]   = cfg_edge[k];
            end
            if (bus_addr == ADDR_W'(NUM_SRC + k)) rd_mux = vec_tab[k];
        end
        if (bus_addr == A_EN)    rd_mux = VEC_W'(en_mask);
        if (bus_addr == A_FORCE) rd_mux = VEC_W'(force_mask);
        if (bus_addr == A_IVR)   rd_mux = irq_norm ? vec_tab[win_id] : spur_vec;
        if (bus_addr == A_SPUR)  rd_mux = spur_vec;
        if (bus_addr == A_PROT)  rd_mux = VEC_W'(protect);
        if (bus_addr == A_PEND)  rd_mux = VEC_W'(pend);
    end

    // Registered read data.
    always_ff @(posedge clk) begin
        if (!rst_n)     bus_rdata <= '0;
        else if (rd_en) bus_rdata <= rd_mux;
    end
endmodule

// File: rtl/intc_vnp_chk.sv
// Module: assertion checker for intc_vnp_top, attached by bind.
// It watches the bus strobes, the arbiter result and the level stack.
module intc_vnp_chk #(
    parameter int NSRC = 32,
    parameter int PW   = 3,
    parameter int DW   = 4,
    parameter int AW   = 7,
    parameter int IDW  = 5,
    parameter logic [AW-1:0] IVR_A = '0,
    parameter logic [AW-1:0] EOI_A = '0
) (
    input logic            clk,
    input logic            rst_n,
    input logic            bus_rd,
    input logic            bus_wr,
    input logic [AW-1:0]   bus_addr,
    input logic            irq_norm,
    input logic            protect,
    input logic            ack_fire,
    input logic            win_valid,
    input logic [IDW-1:0]  win_id,
    input logic [NSRC-1:0] force_mask,
    input logic [PW-1:0]   cur_lvl,
    input logic [DW-1:0]   depth
);
    localparam int DEPTH = 2 ** PW;

    AST_DEPTH_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        depth <= DW'(DEPTH));                                                   // R6
    AST_NEST_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_fire && depth != '0) |=> (cur_lvl > $past(cur_lvl)));             // R6
    AST_EOI_POPS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == EOI_A && depth != '0) |=> (depth == $past(depth) - DW'(1))); // R6
    AST_PROTECT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !bus_wr && bus_addr == IVR_A && protect) |=> ($stable(depth) && $stable(cur_lvl))); // R8
    AST_FORCED_NOT_NORMAL: assert property (@(posedge clk) disable iff (!rst_n)
        irq_norm |-> !force_mask[win_id]);                                      // R9
    AST_SRC0_NEVER_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        win_valid |-> (win_id != '0));                                          // R4
    AST_SPURIOUS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !bus_wr && bus_addr == IVR_A && !irq_norm) |=> $stable(depth)); // R7
endmodule

bind intc_vnp_top intc_vnp_chk #(
    .NSRC (NUM_SRC),
    .PW   (PRIO_BITS),
    .DW   (DEPTH_W),
    .AW   (ADDR_W),
    .IDW  (IDW),
    .IVR_A(A_IVR),
    .EOI_A(A_EOI)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_rd     (bus_rd),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .irq_norm   (irq_norm),
    .protect    (protect),
    .ack_fire   (ack_fire),
    .win_valid  (win_valid),
    .win_id     (win_id),
    .force_mask (force_mask),
    .cur_lvl    (cur_lvl),
    .depth      (depth)
);

// File: tb/test_intc_vnp_top.sv
// Directed bench for intc_vnp_top: one task per scenario, each checking its own results.
module test_intc_vnp_top;
    localparam int A_VEC = 32, A_EN = 64, A_FRC = 65, A_IVR = 66, A_EOI = 67;
    localparam int A_SPUR = 68, A_PROT = 69, A_PEND = 70;
    localparam logic [31:0] SPUR = 32'hDEAD_0000;
    localparam logic [31:0] EN_ALL = 32'hFFFF_FF7E;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] src_in = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [6:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_norm;
    logic        irq_fast;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    intc_vnp_top i_intc_vnp_top (
        .clk(clk), .rst_n(rst_n), .src_in(src_in), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_norm(irq_norm), .irq_fast(irq_fast)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input int addr, input logic [31:0] data);
        bus_wr = 1'b1; bus_addr = 7'(addr); bus_wdata = data;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input int addr, output logic [31:0] data);
        bus_rd = 1'b1; bus_addr = 7'(addr);
        @(negedge clk);
        bus_rd = 1'b0;
        data = bus_rdata;
    endtask

    task automatic pulse(input logic [31:0] bits);
        src_in = src_in | bits;
        @(negedge clk);
        src_in = src_in & ~bits;
        @(negedge clk);
    endtask

    task automatic t_reset;
        logic [31:0] d;
        check("R1 irq_norm", 32'(irq_norm), 0);
        check("R1 irq_fast", 32'(irq_fast), 0);
        rd(A_EN, d);   check("R1 enable mask", d, 0);
        rd(A_PEND, d); check("R1 pending", d, 0);
        rd(A_IVR, d);  check("R1 spurious reset value", d, 0);
    endtask

    task automatic t_level;
        logic [31:0] d;
        wr(3, 32'h2);
        src_in[3] = 1'b1; @(negedge clk);
        check("R2 level raises irq", 32'(irq_norm), 1);
        rd(A_IVR, d); check("R5 vector of src3", d, 32'h1003);
        check("R6 equal level blocked", 32'(irq_norm), 0);
        src_in[3] = 1'b0; wr(A_EOI, 0);
        check("R2 level gone", 32'(irq_norm), 0);
        rd(A_PEND, d); check("R2 level pending follows input", d[3], 0);
    endtask

    task automatic t_edge;
        logic [31:0] d;
        wr(5, 32'h11);
        pulse(32'h20);
        check("R2 edge held", 32'(irq_norm), 1);
        rd(A_PEND, d); check("R2 edge pending bit", 32'(d[5]), 1);
        rd(A_IVR, d);  check("R5 vector of src5", d, 32'h1005);
        rd(A_PEND, d); check("R5 ack clears edge", 32'(d[5]), 0);
        wr(A_EOI, 0);
        check("R2 idle after eoi", 32'(irq_norm), 0);
    endtask

    task automatic t_prio;
        logic [31:0] d;
        wr(9, 32'h14); wr(10, 32'h16); wr(11, 32'h16);
        pulse(32'h0E00);
        rd(A_IVR, d); check("R4 tie lowest id wins", d, 32'h100A);
        check("R6 equal prio no preempt", 32'(irq_norm), 0);
        wr(A_EOI, 0);
        check("R6 eoi reopens", 32'(irq_norm), 1);
        rd(A_IVR, d); check("R4 second of tie", d, 32'h100B);
        wr(A_EOI, 0);
        rd(A_IVR, d); check("R4 lower prio last", d, 32'h1009);
        wr(A_EOI, 0);
        check("R6 all served", 32'(irq_norm), 0);
    endtask

    task automatic t_nest;
        logic [31:0] d;
        wr(12, 32'h12); wr(13, 32'h15); wr(14, 32'h13);
        pulse(32'h1000);
        rd(A_IVR, d); check("R5 src12 taken", d, 32'h100C);
        pulse(32'h2000);
        check("R6 higher preempts", 32'(irq_norm), 1);
        rd(A_IVR, d); check("R6 nested vector", d, 32'h100D);
        pulse(32'h4000);
        check("R6 lower blocked", 32'(irq_norm), 0);
        rd(A_IVR, d); check("R7 spurious while blocked", d, SPUR);
        wr(A_EOI, 0);
        check("R6 pop restores level 2", 32'(irq_norm), 1);
        rd(A_IVR, d); check("R7 no state lost, src14", d, 32'h100E);
        wr(A_EOI, 0); wr(A_EOI, 0);
        check("R6 unwound", 32'(irq_norm), 0);
    endtask

    task automatic t_protect;
        logic [31:0] d;
        wr(A_PROT, 1); wr(15, 32'h13);
        pulse(32'h8000);
        rd(A_IVR, d); check("R8 protected vector", d, 32'h100F);
        check("R8 request kept", 32'(irq_norm), 1);
        rd(A_PEND, d); check("R8 pending kept", 32'(d[15]), 1);
        rd(A_IVR, d); check("R8 repeat read same", d, 32'h100F);
        wr(A_PROT, 0);
        rd(A_IVR, d); check("R5 unprotected ack", d, 32'h100F);
        rd(A_PEND, d); check("R5 pending cleared", 32'(d[15]), 0);
        wr(A_EOI, 0);
    endtask

    task automatic t_mask;
        logic [31:0] d;
        wr(7, 32'h7);
        src_in[7] = 1'b1; @(negedge clk);
        check("R3 masked no irq", 32'(irq_norm), 0);
        rd(A_IVR, d); check("R3 masked not selected", d, SPUR);
        wr(A_EN, EN_ALL | 32'h80);
        check("R3 enabled raises", 32'(irq_norm), 1);
        src_in[7] = 1'b0; @(negedge clk);
        check("R3 released", 32'(irq_norm), 0);
        wr(A_EN, EN_ALL);
    endtask

    task automatic t_fast;
        logic [31:0] d;
        wr(A_FRC, 32'h1_0000); wr(16, 32'h7);
        src_in[16] = 1'b1; @(negedge clk);
        check("R9 forced drives fast", 32'(irq_fast), 1);
        check("R9 forced not normal", 32'(irq_norm), 0);
        rd(A_IVR, d); check("R9 forced not vectored", d, SPUR);
        src_in[16] = 1'b0; @(negedge clk);
        check("R9 fast drops", 32'(irq_fast), 0);
        src_in[0] = 1'b1; @(negedge clk);
        check("R9 src0 masked", 32'(irq_fast), 0);
        wr(A_EN, EN_ALL | 32'h1);
        check("R9 src0 fast", 32'(irq_fast), 1);
        check("R9 src0 not normal", 32'(irq_norm), 0);
        src_in[0] = 1'b0; @(negedge clk);
        check("R9 src0 released", 32'(irq_fast), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        for (int k = 1; k < 32; k++) wr(A_VEC + k, 32'h1000 + 32'(k));
        wr(A_SPUR, SPUR);
        wr(A_EN, EN_ALL);
        t_level();
        t_edge();
        t_prio();
        t_nest();
        t_protect();
        t_mask();
        t_fast();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule